// File: doc/BRIEF.md
# Compare-Match Output Override Controller

This block produces a set of timer output pins from an external counter value and one compare value per channel. With no request pending, a channel's pin flips each time the counter lands on that channel's compare value. Software can store a two-bit request per channel in a small control register. A request can clear the pin on the next match, set it on the next match, or freeze it so that matches are ignored. The block does not contain the counter, the capture logic, the prescaler or the interrupts. It only detects matches, decodes the requests, gates them by timer mode, and holds the register.

The request fields apply only when the timer runs in interval mode or free-running mode. In any other mode, and in free-running mode on a channel whose compare register is used for capture, the channel toggles as if its field held zero. The register keeps its contents until the next register write or a system reset.

Top module: `cmp_pin_override`

## Requirements
- R1: After reset, every pin output is low (0) and every request field reads as zero.
- R2: The control register holds one 2-bit field per channel. Channel m uses bits 2m+1 (set/keep) and 2m (clear/keep). A byte write (`wr_byte_en`=1) replaces the whole register. With no write, the register holds its value.
- R3: A single-bit write (`wr_bit_en`=1) loads `wr_data[0]` into bit `wr_bit_idx` and leaves every other bit unchanged. If a byte write happens in the same cycle, the byte write wins.
- R4: A match event for a channel occurs in a cycle where `cnt_val` equals its compare value. Only one event occurs per counter value. Holding the counter, or rewriting the compare value while the counter stays unchanged, does not produce a second event.
- R5: Field code 00 inverts the pin on each match event.
- R6: Field code 01 drives the pin low (inactive) on a match event.
- R7: Field code 10 drives the pin high (active) on a match event.
- R8: Field code 11 holds the pin level, and matches have no effect on it.
- R9: Mode codes: 0 is interval mode and 1 is free-running mode. In any other mode (2 to 7), every channel behaves as field code 00.
- R10: In mode 1, a channel with its `cap_sel` bit at 1 behaves as code 00. In mode 0, `cap_sel` has no effect.
- R11: A forced level stays in place over later matches while the field keeps its code. After software writes 00 to the field, toggling resumes from the current level.
- R12: A pin changes only on the clock edge that ends a match-event cycle. A register write affects matches starting in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Current counter value |
| cmp_vals | input | NUM_CH*CNT_W | Compare values, channel m at bits m*CNT_W and above |
| tmr_mode | input | 3 | Timer mode code (0 interval, 1 free-running) |
| cap_sel | input | NUM_CH | 1 marks a channel's compare register as used for capture |
| wr_byte_en | input | 1 | Whole-register write strobe |
| wr_bit_en | input | 1 | Single-bit write strobe |
| wr_bit_idx | input | IDX_W | Bit index for a single-bit write |
| wr_data | input | 2*NUM_CH | Write data; bit 0 is used for single-bit writes |
| pin_out | output | NUM_CH | Output pin levels |

## Verification
The assertions assume that the counter, the compare values, the mode and the capture flags are stable across each clock edge and change only between edges. They also assume that the single-bit index always names an existing register bit. The bench changes every input just after the falling clock edge and draws bit indices from the legal range only. It keeps the counter and the compare values in a small range so that matches, held counts and compare rewrites occur often. The reference model records the last counter value and whether each channel has already fired at that value. It computes the expected pins from that record without using the design's internals.

// File: rtl/cmp_pin_override_pkg.sv
package cmp_pin_override_pkg;
   localparam int MODE_W = 3;
   localparam logic [MODE_W-1:0] MODE_INTERVAL = 3'd0;
   localparam logic [MODE_W-1:0] MODE_FREERUN  = 3'd1;

   typedef enum logic [1:0] {
      REQ_TOGGLE = 2'b00,
      REQ_CLEAR  = 2'b01,
      REQ_SET    = 2'b10,
      REQ_KEEP   = 2'b11
   } pin_req_e;
endpackage

// File: rtl/cmp_ctrl_reg.sv
module cmp_ctrl_reg #(
   parameter int NUM_CH = 4,
   localparam int REG_W = 2 * NUM_CH,
   localparam int IDX_W = (REG_W > 1) ? $clog2(REG_W) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_byte_en,
   input  logic             wr_bit_en,
   input  logic [IDX_W-1:0] wr_bit_idx,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] ctrl_q
);
   logic [REG_W-1:0] ctrl_d;
   logic             idx_ok;

   assign idx_ok = (int'(wr_bit_idx) < REG_W);

   always_comb begin
      ctrl_d = ctrl_q;
      if (wr_byte_en) begin
         ctrl_d = wr_data;
      end else if (wr_bit_en && idx_ok) begin
         ctrl_d[wr_bit_idx] = wr_data[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else        ctrl_q <= ctrl_d;
   end

   AST_BYTE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_byte_en |=> ctrl_q == $past(wr_data)); // R2
   AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_byte_en && !wr_bit_en) |=> $stable(ctrl_q)); // R2
   AST_BIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_bit_en && !wr_byte_en && idx_ok) |=> ctrl_q[$past(wr_bit_idx)] == $past(wr_data[0])); // R3
endmodule

// File: rtl/cmp_match_det.sv
module cmp_match_det #(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [CNT_W-1:0]        cnt_val,
   input  logic [NUM_CH*CNT_W-1:0] cmp_vals,
   output logic [NUM_CH-1:0]       hit
);
   logic [CNT_W-1:0]  cnt_q;
   logic              cnt_moved;
   logic [NUM_CH-1:0] fired_q;

   assign cnt_moved = (cnt_val != cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_val;
   end

   for (genvar m = 0; m < NUM_CH; m++) begin : g_ch
      logic eq;
      assign eq     = (cnt_val == cmp_vals[m*CNT_W +: CNT_W]);
      assign hit[m] = eq && (cnt_moved || !fired_q[m]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         fired_q[m] <= 1'b0;
         else if (cnt_moved) fired_q[m] <= hit[m];
         else                fired_q[m] <= fired_q[m] | hit[m];
      end

      AST_ONE_HIT_PER_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
         hit[m] |=> !(hit[m] && cnt_val == $past(cnt_val))); // R4
   end
endmodule

// File: rtl/cmp_pin_ctrl.sv
module cmp_pin_ctrl
   import cmp_pin_override_pkg::*;
#(
   parameter int NUM_CH = 4,
   localparam int REG_W = 2 * NUM_CH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] hit,
   input  logic [REG_W-1:0]  ctrl_q,
   input  logic [MODE_W-1:0] tmr_mode,
   input  logic [NUM_CH-1:0] cap_sel,
   output logic [NUM_CH-1:0] pin_q
);
   logic mode_int, mode_free, mode_other;

   assign mode_int   = (tmr_mode == MODE_INTERVAL);
   assign mode_free  = (tmr_mode == MODE_FREERUN);
   assign mode_other = !mode_int && !mode_free;

   for (genvar m = 0; m < NUM_CH; m++) begin : g_ch
      logic     req_ok;
      pin_req_e req;

      assign req_ok = mode_int || (mode_free && !cap_sel[m]);
      assign req    = req_ok ? pin_req_e'(ctrl_q[2*m +: 2]) : REQ_TOGGLE;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pin_q[m] <= 1'b0;
         end else if (hit[m]) begin
            unique case (req)
               REQ_TOGGLE: pin_q[m] <= ~pin_q[m];
               REQ_CLEAR:  pin_q[m] <= 1'b0;
               REQ_SET:    pin_q[m] <= 1'b1;
               REQ_KEEP:   pin_q[m] <= pin_q[m];
            endcase
         end
      end

      AST_TOGGLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[m] && mode_int && ctrl_q[2*m +: 2] == 2'b00) |=> pin_q[m] != $past(pin_q[m])); // R5
      AST_CLEAR_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[m] && mode_int && ctrl_q[2*m +: 2] == 2'b01) |=> !pin_q[m]); // R6
      AST_SET_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[m] && mode_int && ctrl_q[2*m +: 2] == 2'b10) |=> pin_q[m]); // R7
      AST_KEEP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_int && ctrl_q[2*m +: 2] == 2'b11) |=> $stable(pin_q[m])); // R8
      AST_OTHER_MODE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[m] && mode_other) |=> pin_q[m] != $past(pin_q[m])); // R9
      AST_CAPTURE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[m] && mode_free && cap_sel[m]) |=> pin_q[m] != $past(pin_q[m])); // R10
      AST_NO_HIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
         !hit[m] |=> $stable(pin_q[m])); // R12
   end
endmodule

// File: rtl/cmp_pin_override.sv
module cmp_pin_override
   import cmp_pin_override_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 16,
   localparam int REG_W = 2 * NUM_CH,
   localparam int IDX_W = (REG_W > 1) ? $clog2(REG_W) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [CNT_W-1:0]        cnt_val,
   input  logic [NUM_CH*CNT_W-1:0] cmp_vals,
   input  logic [MODE_W-1:0]       tmr_mode,
   input  logic [NUM_CH-1:0]       cap_sel,
   input  logic                    wr_byte_en,
   input  logic                    wr_bit_en,
   input  logic [IDX_W-1:0]        wr_bit_idx,
   input  logic [REG_W-1:0]        wr_data,
   output logic [NUM_CH-1:0]       pin_out
);
   logic [REG_W-1:0]  ctrl_q;
   logic [NUM_CH-1:0] hit;

   initial begin
      AST_PARAM_CH: assert (NUM_CH >= 1 && NUM_CH <= 16)
         else $error("NUM_CH out of range"); // R2
      AST_PARAM_CNT: assert (CNT_W >= 2 && CNT_W <= 32)
         else $error("CNT_W out of range"); // R4
   end

   cmp_ctrl_reg #(.NUM_CH(NUM_CH)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_byte_en(wr_byte_en),
      .wr_bit_en (wr_bit_en),
      .wr_bit_idx(wr_bit_idx),
      .wr_data   (wr_data),
      .ctrl_q    (ctrl_q)
   );

   cmp_match_det #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_val (cnt_val),
      .cmp_vals(cmp_vals),
      .hit     (hit)
   );

   cmp_pin_ctrl #(.NUM_CH(NUM_CH)) u_pins (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .ctrl_q  (ctrl_q),
      .tmr_mode(tmr_mode),
      .cap_sel (cap_sel),
      .pin_q   (pin_out)
   );
endmodule

// File: tb/cmp_pin_override_tb.sv
module cmp_pin_override_tb;
   localparam int NCH = 4;
   localparam int CW  = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [CW-1:0]  cnt_val = '0;
   logic [NCH*CW-1:0] cmp_vals = '0;
   logic [2:0]     tmr_mode = 3'd0;
   logic [NCH-1:0] cap_sel = '0;
   logic           wr_byte_en = 1'b0;
   logic           wr_bit_en = 1'b0;
   logic [2:0]     wr_bit_idx = '0;
   logic [7:0]     wr_data = '0;
   logic [NCH-1:0] pin_out;

   int    checks = 0;
   int    failures = 0;
   string cur_req = "R1";
   bit    cmp_on = 1'b0;

   always #5 clk = ~clk;

   cmp_pin_override u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cmp_vals(cmp_vals),
      .tmr_mode(tmr_mode), .cap_sel(cap_sel), .wr_byte_en(wr_byte_en),
      .wr_bit_en(wr_bit_en), .wr_bit_idx(wr_bit_idx), .wr_data(wr_data),
      .pin_out(pin_out)
   );

   // Behavioural reference model
   int       m_reg;
   bit [3:0] m_pin;
   int       m_last_cnt;
   bit [3:0] m_done;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_reg = 0; m_pin = '0; m_last_cnt = 0; m_done = '0;
      end else begin
         for (int m = 0; m < NCH; m++) begin
            int  cv;
            int  code;
            bit  event_now;
            bit  gated;
            cv = int'(cmp_vals[m*CW +: CW]);
            event_now = (int'(cnt_val) == cv) &&
                        ((int'(cnt_val) != m_last_cnt) || !m_done[m]);
            if (int'(cnt_val) != m_last_cnt) m_done[m] = event_now;
            else if (event_now)              m_done[m] = 1'b1;
            gated = (tmr_mode == 3'd0) || (tmr_mode == 3'd1 && !cap_sel[m]);
            code  = gated ? ((m_reg >> (2*m)) & 3) : 0;
            if (event_now) begin
               case (code)
                  0: m_pin[m] = ~m_pin[m];
                  1: m_pin[m] = 1'b0;
                  2: m_pin[m] = 1'b1;
                  default: ;
               endcase
            end
         end
         m_last_cnt = int'(cnt_val);
         if (wr_byte_en) m_reg = int'(wr_data);
         else if (wr_bit_en) begin
            if (wr_data[0]) m_reg = m_reg | (1 << wr_bit_idx);
            else            m_reg = m_reg & ~(1 << wr_bit_idx);
         end
      end
   end

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s pin_out actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on && rst_n) chk(cur_req, pin_out, m_pin);
   end

   task automatic step(input int c);
      cnt_val = c[CW-1:0];
      @(negedge clk);
   endtask

   task automatic sweep(input int n);
      for (int i = 0; i < n; i++) step(i % 8);
   endtask

   task automatic wr_byte(input logic [7:0] d);
      wr_byte_en = 1'b1; wr_data = d;
      step(15);
      wr_byte_en = 1'b0;
   endtask

   task automatic set_cmp(input int a, input int b, input int c, input int d);
      cmp_vals = {d[CW-1:0], c[CW-1:0], b[CW-1:0], a[CW-1:0]};
   endtask

   initial begin
      set_cmp(2, 3, 5, 6);
      cnt_val = 16'd15;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", pin_out, 4'b0000);
      cmp_on = 1'b1;

      cur_req = "R5"; sweep(24);

      cur_req = "R4";
      step(2); step(2); step(2); step(2);
      cmp_vals[CW-1:0] = 16'd9; step(2);
      cmp_vals[CW-1:0] = 16'd2; step(2); step(2);
      step(3); step(2);

      // channel codes: ch0=00, ch1=11, ch2=01, ch3=10
      cur_req = "R2"; wr_byte(8'b10_01_11_00);
      cur_req = "R6"; sweep(16);
      cur_req = "R7"; sweep(16);
      cur_req = "R8"; sweep(16);

      cur_req = "R11"; wr_byte(8'h00); sweep(24);

      cur_req = "R3";
      wr_bit_en = 1'b1; wr_bit_idx = 3'd1; wr_data = 8'h01; step(15);
      wr_bit_en = 1'b0; sweep(16);
      wr_bit_en = 1'b1; wr_bit_idx = 3'd6; wr_data = 8'h01;
      wr_byte_en = 1'b1; wr_data = 8'h10; step(15);
      wr_bit_en = 1'b0; wr_byte_en = 1'b0; sweep(16);

      cur_req = "R9"; wr_byte(8'hFF);
      for (int md = 2; md < 8; md++) begin
         tmr_mode = md[2:0]; sweep(10);
      end

      cur_req = "R10";
      tmr_mode = 3'd1; cap_sel = 4'b0101; wr_byte(8'h55); sweep(24);
      wr_byte(8'hAA); sweep(16);
      tmr_mode = 3'd0; sweep(16);
      cap_sel = 4'b0000; wr_byte(8'h00);

      cur_req = "R12";
      set_cmp(1, 4, 4, 7);
      for (int i = 0; i < 600; i++) begin
         tmr_mode   = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(2, 7)) : 3'($urandom_range(0, 1));
         cap_sel    = ($urandom_range(0, 7) == 0) ? 4'($urandom) : cap_sel;
         wr_byte_en = ($urandom_range(0, 9) == 0);
         wr_bit_en  = ($urandom_range(0, 7) == 0);
         wr_bit_idx = 3'($urandom_range(0, 7));
         wr_data    = 8'($urandom);
         if ($urandom_range(0, 15) == 0) cmp_vals[CW-1:0] = 16'($urandom_range(0, 7));
         step($urandom_range(0, 7));
      end
      wr_byte_en = 1'b0; wr_bit_en = 1'b0;
      step(0);
      cmp_on = 1'b0;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule